// File: doc/BRIEF.md
# Clock Calibration Measurement Unit

This block compares the frequency of a measured clock against the bus clock, which also serves as the reference. Software writes a cycle count into a 16-bit duration register and sets a start bit. In the reference domain a down-counter is loaded from that register. In the measured domain a calibration counter is cleared and then counts measured-clock cycles. When the down-counter has run out, the measured domain freezes its count in a capture register. The reference domain then copies that value into a 24-bit read-only result, raises a sticky done flag and clears the start bit. An interrupt line is high while both the flag and its enable bit are set.

A control bit selects one of two measured clocks. Clearing the start bit in the middle of a run abandons the run: the result is not updated and the flag is not set. The done flag is never cleared by hardware. A bus read marked as a read-modify-write returns the flag as 1, so that a software bit-set on another control bit cannot clear the flag by mistake.

Top module: `clk_cal_unit`

## Requirements
- R1: After reset, the control word (address 0) reads 0x0000, the duration register (address 1) reads 0x8000, both result words (addresses 2 and 3) read 0 and `irq` is 0.
- R2: Control word layout: bit 0 is the interrupt enable, bit 1 the done flag, bit 2 the clock select and bit 4 the start bit. All other bits read 0 and ignore writes.
- R3: Writing the control word with bit 4 = 1 while idle loads the down-counter from the duration value D and clears the calibration counter. On completion, address 2 bits 7:0 hold result bits 7:0 and address 3 holds result bits 23:8. The result equals the number of measured-clock cycles in D+1 reference cycles, within ±3.
- R4: Completion sets the done flag whatever the enable says, and clears the start bit in the same cycle.
- R5: `irq` is 1 exactly when both the done flag and the interrupt enable are 1.
- R6: Writing 0 to bit 1 clears the flag. Writing 1 to bit 1 leaves it unchanged. A hardware set in the same cycle as a clearing write wins.
- R7: A read of the control word with `rmw` = 1 returns bit 1 as 1, whatever the flag holds. A read with `rmw` = 0 returns the flag itself.
- R8: Hardware never clears the flag. Starting a new run with the flag set leaves it at 1.
- R9: Writing bit 4 = 0 during a run aborts it. The start bit reads 0, the flag is not set and the result is unchanged. Start requests written while the abort is still draining are ignored.
- R10: Clock select 0 measures `mclk_a` and 1 measures `mclk_b`. Writes to the clock select take effect only while the unit is idle.
- R11: The calibration counter saturates at its all-ones value and does not wrap.
- R12: The duration register is read/write over all 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk_a | input | 1 | Measured clock, select 0 |
| mclk_b | input | 1 | Measured clock, select 1 |
| wr | input | 1 | Register write strobe |
| addr | input | 2 | Word address: 0 control, 1 duration, 2 result low, 3 result high |
| wdata | input | 16 | Write data |
| rmw | input | 1 | Marks the current read as a read-modify-write |
| rdata | output | 16 | Read data, combinational from `addr` |
| irq | output | 1 | Interrupt request |

## Verification
Register reads are combinational from `addr`, so the bench samples `rdata` 1 ns after a falling edge. A write becomes visible from the next rising edge, and `irq` changes at the same edge as the flag. The result and the flag are due D+1 reference cycles after the start edge, plus the handshake delay: up to three measured-clock edges and three reference edges. The bench therefore polls the start bit with a bounded loop and then waits 20 more cycles before it reads. Each synchronised boundary of the counting window can move by a measured cycle, so counts are checked against a ±3 window around the ideal value computed in the bench.

// File: rtl/ccu_pkg.sv
`timescale 1ns/1ps
package ccu_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;
    localparam int LO_W   = 8;

    // control word bit positions
    localparam int B_IEN   = 0;
    localparam int B_FLAG  = 1;
    localparam int B_CKSEL = 2;
    localparam int B_START = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 2'd0,
        A_DUR    = 2'd1,
        A_RES_LO = 2'd2,
        A_RES_HI = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_STOP = 2'd2
    } ref_state_e;

    typedef struct packed {
        logic start;
        logic cksel;
        logic flag;
        logic ien;
    } ctrl_t;

    typedef struct packed {
        logic              wr;
        reg_addr_e         addr;
        logic [DATA_W-1:0] wdata;
        logic              rmw;
    } bus_req_t;

    function automatic logic [DATA_W-1:0] ctrl_view(ctrl_t c, logic rmw);
        logic [DATA_W-1:0] v;
        v          = '0;
        v[B_IEN]   = c.ien;
        v[B_FLAG]  = c.flag | rmw;
        v[B_CKSEL] = c.cksel;
        v[B_START] = c.start;
        return v;
    endfunction

endpackage

// File: rtl/ccu_sync.sv
`timescale 1ns/1ps
module ccu_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) ff <= RST_VAL;
                else     ff <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) ff <= {STAGES{RST_VAL}};
                else     ff <= {ff[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = ff[STAGES-1];
endmodule

// File: rtl/ccu_meas_count.sv
`timescale 1ns/1ps
module ccu_meas_count #(
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             mclk,
    input  logic             mrst,
    input  logic             run_req,
    output logic             echo,
    output logic [CNT_W-1:0] cap,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             run_s;
    logic             run_d;
    logic [CNT_W-1:0] cnt;

    ccu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_run_sync (
        .clk (mclk),
        .rst (mrst),
        .d   (run_req),
        .q   (run_s)
    );

    always_ff @(posedge mclk) begin
        if (mrst) begin
            run_d <= 1'b0;
            cnt   <= '0;
            cap   <= '0;
        end else begin
            run_d <= run_s;
            if (run_s && !run_d) begin
                cnt <= '0;
            end else if (run_s && (cnt != CNT_MAX)) begin
                cnt <= cnt + CNT_W'(1);
            end
            if (run_d && !run_s) begin
                cap <= cnt;
            end
        end
    end

    assign echo  = run_d;
    assign cnt_o = cnt;
endmodule

// File: rtl/ccu_ref_ctrl.sv
`timescale 1ns/1ps
module ccu_ref_ctrl
    import ccu_pkg::*;
#(
    parameter int             CNT_W       = 24,
    parameter int             DUR_W       = 16,
    parameter logic [DUR_W-1:0] DUR_RST   = 16'h8000,
    parameter int             SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic              echo,
    input  logic [CNT_W-1:0]  cap,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl_q,
    output logic [CNT_W-1:0]  result,
    output logic              busy,
    output logic              run_req
);
    ref_state_e       state;
    logic [DUR_W-1:0] dur_reg;
    logic [DUR_W-1:0] dur_cnt;
    logic             abort_q;
    logic             echo_s;
    logic             wr_ctrl;
    logic             wr_dur;

    ccu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_echo_sync (
        .clk (clk),
        .rst (rst),
        .d   (echo),
        .q   (echo_s)
    );

    assign wr_ctrl = req.wr && (req.addr == A_CTRL);
    assign wr_dur  = req.wr && (req.addr == A_DUR);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            ctrl_q  <= '0;
            dur_reg <= DUR_RST;
            dur_cnt <= '0;
            abort_q <= 1'b0;
            run_req <= 1'b0;
            result  <= '0;
        end else begin
            if (wr_dur) begin
                dur_reg <= req.wdata[DUR_W-1:0];
            end
            if (wr_ctrl) begin
                ctrl_q.ien <= req.wdata[B_IEN];
                if (!req.wdata[B_FLAG]) ctrl_q.flag <= 1'b0;
            end
            case (state)
                ST_IDLE: begin
                    if (wr_ctrl) begin
                        ctrl_q.cksel <= req.wdata[B_CKSEL];
                        if (req.wdata[B_START]) begin
                            ctrl_q.start <= 1'b1;
                            run_req      <= 1'b1;
                            dur_cnt      <= dur_reg;
                            abort_q      <= 1'b0;
                            state        <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (dur_cnt != '0) dur_cnt <= dur_cnt - DUR_W'(1);
                    if (wr_ctrl && !req.wdata[B_START]) begin
                        ctrl_q.start <= 1'b0;
                        abort_q      <= 1'b1;
                    end
                    if (echo_s && ((dur_cnt == '0) || abort_q)) begin
                        run_req <= 1'b0;
                        state   <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (!echo_s) begin
                        if (!abort_q) begin
                            result       <= cap;
                            ctrl_q.flag  <= 1'b1;
                            ctrl_q.start <= 1'b0;
                        end
                        abort_q <= 1'b0;
                        state   <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);

    always_comb begin
        case (req.addr)
            A_CTRL:   rdata = ctrl_view(ctrl_q, req.rmw);
            A_DUR:    rdata = DATA_W'(dur_reg);
            A_RES_LO: rdata = DATA_W'(result[LO_W-1:0]);
            A_RES_HI: rdata = DATA_W'(result[CNT_W-1:LO_W]);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/clk_cal_unit.sv
`timescale 1ns/1ps
module clk_cal_unit
    import ccu_pkg::*;
#(
    parameter int               CNT_W       = 24,
    parameter int               DUR_W       = 16,
    parameter logic [DUR_W-1:0] DUR_RST     = 16'h8000,
    parameter int               SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mclk_a,
    input  logic        mclk_b,
    input  logic        wr,
    input  logic [1:0]  addr,
    input  logic [15:0] wdata,
    input  logic        rmw,
    output logic [15:0] rdata,
    output logic        irq
);
    bus_req_t         req;
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] result;
    logic [CNT_W-1:0] cap;
    logic [CNT_W-1:0] cnt_dbg;
    logic             busy;
    logic             run_req;
    logic             echo;
    logic             mclk_sel;
    logic             mrst;
    logic             ien_w, flag_w, start_w, cksel_w;

    assign req.wr    = wr;
    assign req.addr  = reg_addr_e'(addr);
    assign req.wdata = wdata;
    assign req.rmw   = rmw;

    assign ien_w   = ctrl_q.ien;
    assign flag_w  = ctrl_q.flag;
    assign start_w = ctrl_q.start;
    assign cksel_w = ctrl_q.cksel;

    // selection only changes while idle, so no run sees a switch
    assign mclk_sel = cksel_w ? mclk_b : mclk_a;

    ccu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_mrst_sync (
        .clk (mclk_sel),
        .rst (1'b0),
        .d   (rst),
        .q   (mrst)
    );

    ccu_ref_ctrl #(
        .CNT_W       (CNT_W),
        .DUR_W       (DUR_W),
        .DUR_RST     (DUR_RST),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_ref (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .echo    (echo),
        .cap     (cap),
        .rdata   (rdata),
        .ctrl_q  (ctrl_q),
        .result  (result),
        .busy    (busy),
        .run_req (run_req)
    );

    ccu_meas_count #(
        .CNT_W       (CNT_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_meas (
        .mclk    (mclk_sel),
        .mrst    (mrst),
        .run_req (run_req),
        .echo    (echo),
        .cap     (cap),
        .cnt_o   (cnt_dbg)
    );

    assign irq = flag_w & ien_w;
endmodule

// File: rtl/clk_cal_unit_chk.sv
`timescale 1ns/1ps
module clk_cal_unit_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             mclk,
    input logic             mrst,
    input logic             wr,
    input logic [1:0]       addr,
    input logic [15:0]      wdata,
    input logic             irq,
    input logic             ien,
    input logic             flag,
    input logic             start,
    input logic             cksel,
    input logic             busy,
    input logic [CNT_W-1:0] result,
    input logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(wr && (addr == 2'd0) && !wdata[1]));

    // R4
    flag_ends_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> !start);

    // R3
    result_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> $fell(start));

    // R5
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> ien);

    // R10
    cksel_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cksel));

    // R11
    count_saturates_chk: assert property (@(posedge mclk) disable iff (mrst)
        (cnt == CNT_MAX) |=> ((cnt == CNT_MAX) || (cnt == '0)));
endmodule

bind clk_cal_unit clk_cal_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .mclk   (mclk_sel),
    .mrst   (mrst),
    .wr     (wr),
    .addr   (addr),
    .wdata  (wdata),
    .irq    (irq),
    .ien    (ien_w),
    .flag   (flag_w),
    .start  (start_w),
    .cksel  (cksel_w),
    .busy   (busy),
    .result (result),
    .cnt    (cnt_dbg)
);

// File: tb/tb_clk_cal_unit.sv
`timescale 1ns/1ps
module tb_clk_cal_unit;
    localparam int TCLK = 4;
    localparam int TA   = 10;
    localparam int TB   = 6;
    localparam int NVEC = 5;
    // {ien, cksel, duration}
    localparam logic [17:0] VECS [NVEC] = '{
        {1'b1, 1'b0, 16'd40},
        {1'b0, 1'b1, 16'd100},
        {1'b1, 1'b1, 16'd1000},
        {1'b0, 1'b0, 16'd255},
        {1'b1, 1'b0, 16'd700}
    };

    logic        clk = 0, mclk_a = 0, mclk_b = 0, rst = 1;
    logic        wr = 0, rmw = 0;
    logic [1:0]  addr = 0;
    logic [15:0] wdata = 0;
    logic [15:0] rdata, rdata_sat;
    logic        irq, irq_sat;
    int          n_chk = 0, n_bad = 0, cyc = 0;

    always #(TCLK/2) clk = ~clk;
    always #(TA/2) mclk_a = ~mclk_a;
    always #(TB/2) mclk_b = ~mclk_b;

    clk_cal_unit dut (
        .clk(clk), .rst(rst), .mclk_a(mclk_a), .mclk_b(mclk_b), .wr(wr),
        .addr(addr), .wdata(wdata), .rmw(rmw), .rdata(rdata), .irq(irq)
    );

    clk_cal_unit #(.CNT_W(12)) dut_sat (
        .clk(clk), .rst(rst), .mclk_a(mclk_a), .mclk_b(mclk_b), .wr(wr),
        .addr(addr), .wdata(wdata), .rmw(rmw), .rdata(rdata_sat), .irq(irq_sat)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_win(input string req, input string what,
                           input int act, input int exp);
        n_chk++;
        if (act < exp - 3 || act > exp + 3) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d +/-3", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr = 1; addr = a; wdata = d;
        @(negedge clk);
        wr = 0;
    endtask

    task automatic rd_reg(input logic [1:0] a, input logic m,
                          output logic [15:0] d, output logic [15:0] ds);
        @(negedge clk);
        addr = a; rmw = m;
        #1;
        d = rdata; ds = rdata_sat;
        rmw = 0;
    endtask

    task automatic wait_done();
        logic [15:0] v, vs;
        for (int i = 0; i < 40000; i++) begin
            rd_reg(2'd0, 1'b0, v, vs);
            if (!v[4]) break;
        end
        repeat (20) @(negedge clk);
    endtask

    task automatic rd_result(output int cnt, output int cnt_sat);
        logic [15:0] lo, hi, los, his;
        rd_reg(2'd2, 1'b0, lo, los);
        rd_reg(2'd3, 1'b0, hi, his);
        cnt     = {hi, lo[7:0]};
        cnt_sat = {his, los[7:0]};
    endtask

    initial begin
        logic [15:0] v, vs;
        int c, cs, prev;
        repeat (10) @(negedge clk);
        rst = 0;
        repeat (10) @(negedge clk);

        // R1 reset state
        rd_reg(2'd0, 1'b0, v, vs); chk("R1", "ctrl reset", v, 16'h0000);
        rd_reg(2'd1, 1'b0, v, vs); chk("R1", "duration reset", v, 16'h8000);
        rd_reg(2'd2, 1'b0, v, vs); chk("R1", "result lo reset", v, 0);
        rd_reg(2'd3, 1'b0, v, vs); chk("R1", "result hi reset", v, 0);
        chk("R1", "irq reset", irq, 0);

        // R12 duration read/write
        wr_reg(2'd1, 16'h1234);
        rd_reg(2'd1, 1'b0, v, vs); chk("R12", "duration rw", v, 16'h1234);

        // R3 R4 R5 R10 vector walk
        for (int i = 0; i < NVEC; i++) begin
            logic ien, sel;
            int d, t;
            ien = VECS[i][17]; sel = VECS[i][16]; d = int'(VECS[i][15:0]);
            t = sel ? TB : TA;
            wr_reg(2'd1, VECS[i][15:0]);
            wr_reg(2'd0, 16'h0010 | (16'(sel) << 2) | 16'(ien));
            wait_done();
            rd_reg(2'd0, 1'b0, v, vs);
            chk("R4", "ctrl after done", v, 16'h0002 | (16'(sel) << 2) | 16'(ien));
            chk("R5", "irq after done", irq, ien);
            rd_result(c, cs);
            chk_win("R3", "count", c, ((d + 1) * TCLK) / t);
        end

        // R7 rmw read returns flag as 1
        wr_reg(2'd0, 16'h0000);
        rd_reg(2'd0, 1'b0, v, vs); chk("R7", "plain read flag", v, 16'h0000);
        rd_reg(2'd0, 1'b1, v, vs); chk("R7", "rmw read flag", v, 16'h0002);

        // R6 flag write semantics
        wr_reg(2'd1, 16'd40);
        wr_reg(2'd0, 16'h0011);
        wait_done();
        chk("R5", "irq set", irq, 1);
        wr_reg(2'd0, 16'h0003);
        rd_reg(2'd0, 1'b0, v, vs); chk("R6", "write 1 keeps flag", v, 16'h0003);
        wr_reg(2'd0, 16'h0001);
        rd_reg(2'd0, 1'b0, v, vs); chk("R6", "write 0 clears flag", v, 16'h0001);
        chk("R6", "irq cleared", irq, 0);

        // R8 flag survives a new start; R10 select frozen while running
        wr_reg(2'd0, 16'h0010);
        wait_done();
        wr_reg(2'd1, 16'd300);
        wr_reg(2'd0, 16'h0012);
        repeat (20) @(negedge clk);
        rd_reg(2'd0, 1'b0, v, vs); chk("R8", "flag kept during run", v, 16'h0012);
        wr_reg(2'd0, 16'h0016);
        rd_reg(2'd0, 1'b0, v, vs); chk("R10", "select write ignored", v, 16'h0012);
        wait_done();
        rd_reg(2'd0, 1'b0, v, vs); chk("R8", "flag after run", v, 16'h0002);
        rd_result(c, cs);
        chk_win("R10", "count on clock a", c, (301 * TCLK) / TA);
        prev = c;

        // R9 abort
        wr_reg(2'd1, 16'd2000);
        wr_reg(2'd0, 16'h0010);
        repeat (50) @(negedge clk);
        wr_reg(2'd0, 16'h0000);
        wr_reg(2'd0, 16'h0010);
        repeat (200) @(negedge clk);
        rd_reg(2'd0, 1'b0, v, vs); chk("R9", "ctrl after abort", v, 16'h0000);
        rd_result(c, cs);
        chk("R9", "result kept", c, prev);

        // R2 reserved bits
        wr_reg(2'd0, 16'hFFEC);
        rd_reg(2'd0, 1'b0, v, vs); chk("R2", "reserved bits", v, 16'h0004);
        wr_reg(2'd0, 16'h0000);

        // R11 saturation on 12-bit instance
        wr_reg(2'd1, 16'd8000);
        wr_reg(2'd0, 16'h0014);
        wait_done();
        rd_result(c, cs);
        chk("R11", "saturated count", cs, 32'h0FFF);
        chk_win("R3", "large count", c, (8001 * TCLK) / TB);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule